// File: doc/BRIEF.md
# Multichannel Hook-State Debounce Detector

This block watches four subscriber line channels and decides, frame by frame, whether each line is off-hook or on-hook. Each channel delivers one 8-bit loop-current code on every 8 kHz frame tick. The code is 0.1 mA per LSB. Each code goes through a two-level comparator. The comparator result then passes through a debounce counter that steps at the frame rate. The filtered result becomes the channel's hook status bit.

A status change latches a sticky per-channel pending flag. The interrupt output is the OR of the pending flags, gated off by a mask bit. Software clears the flags by writing ones.

Configuration uses a plain write port with a 3-bit address and 8-bit data. The thresholds come from one of two sources, picked by a select bit:
- Fixed defaults: 7 mA on-level and 2 mA hysteresis.
- Two programmable words, each saturating at 20 mA.

The debounce length is set in 0.125 ms frame steps, from 1 to 16 frames.

Top module: `hook_watch`

## Requirements
- R1: After reset all status bits and pending flags are 0, `irq` is 0, the default threshold source is selected, the debounce field is 0 and the mask is clear.
- R2: A channel whose comparator is in the on-hook state goes off-hook at a tick when the sample is greater than or equal to the on-level. With the defaults the on-level is 70.
- R3: A channel whose comparator is in the off-hook state returns on-hook only at a tick when the sample is below the off-level. The off-level is the on-level minus the hysteresis, floored at 0. With the defaults the off-level is 50, so a sample of 50 keeps it off-hook and 49 releases it.
- R4: Register map for writes (`wrEn` high, value taken at the clock edge):
  - address 0 bit 0 is the threshold source: 1 selects the defaults, 0 selects the programmable words.
  - address 1 is the programmable on-level word.
  - address 2 is the programmable hysteresis word.
  - Both programmable words store min(data, 200).
- R5: Debounce, with DB the 4-bit field at address 3 bits [3:0]:
  - A counter steps up on each tick where the comparator result differs from the status bit.
  - It steps down toward 0 on each tick where they agree.
  - A differing tick that finds the counter at or above DB flips the status bit and clears the counter. So DB+1 consecutive differing ticks flip it.
- R6: Samples presented without a frame tick are ignored; status bits change only on the clock edge that follows a tick.
- R7: Each status bit change sets that channel's pending flag (`irqFlags[n]`). `irq` is high whenever any flag is set and the mask is clear.
- R8: Address 4 bit 0 is the mask. While it is 1, `irq` stays 0 but flags still collect, and clearing the mask exposes them.
- R9: Writing address 5 clears the flags whose data bits are 1, with bit n clearing channel n. A change in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameTick | input | 1 | One-cycle pulse per 0.125 ms frame |
| loopCur | input | NCH*8 | Loop-current codes, channel n in bits [8n+7:8n] |
| wrEn | input | 1 | Configuration write strobe |
| wrAddr | input | 3 | Configuration write address |
| wrData | input | 8 | Configuration write data |
| hookStatus | output | NCH | Debounced status, 1 = off-hook |
| irqFlags | output | NCH | Sticky per-channel change flags |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench builds the block with its default of four channels, so every status, flag and clear bit is visible. The 8-bit data word also carries all four clear bits.

Directed frames hit the exact comparator boundaries: 69 and 70 with the defaults, 50 and 49 for release, and 199 and 200 after saturating writes. A debounce field of 3 shows the up and down counting before a flip.

A long random phase follows. It mixes frame ticks, samples near the thresholds and writes to all six addresses. A behavioural model checks status, flags and interrupt on every clock, which covers a flag set and a clear landing in the same cycle.

// File: rtl/hook_watch_pkg.sv
package hook_watch_pkg;
  localparam int CUR_W = 8;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int DB_W = 4;
  localparam int DEF_ON = 70;
  localparam int DEF_HYST = 20;
  localparam int WORD_MAX = 200;

  typedef enum logic [ADDR_W-1:0] {
    REG_SRC  = 3'd0,
    REG_ON   = 3'd1,
    REG_HYST = 3'd2,
    REG_DBNC = 3'd3,
    REG_MASK = 3'd4,
    REG_CLR  = 3'd5
  } regAddr_t;

  typedef struct packed {
    logic             tick;
    logic             clrStb;
    logic [CUR_W-1:0] onLevel;
    logic [CUR_W-1:0] offLevel;
    logic [DB_W-1:0]  dbLimit;
  } ctrlStrobe_t;
endpackage

// File: rtl/hook_watch_ctrl.sv
module hook_watch_ctrl
  import hook_watch_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameTick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output ctrlStrobe_t       strb,
  output logic              maskOn
);
  logic             useDefault;
  logic [CUR_W-1:0] onWord;
  logic [CUR_W-1:0] hystWord;
  logic [DB_W-1:0]  dbField;
  logic [CUR_W-1:0] onEff;
  logic [CUR_W-1:0] hystEff;

  function automatic logic [CUR_W-1:0] satWord(input logic [DATA_W-1:0] v);
    return (v > DATA_W'(WORD_MAX)) ? CUR_W'(WORD_MAX) : CUR_W'(v);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      useDefault <= 1'b1;
      onWord     <= '0;
      hystWord   <= '0;
      dbField    <= '0;
      maskOn     <= 1'b0;
    end else if (wrEn) begin
      case (regAddr_t'(wrAddr))
        REG_SRC:  useDefault <= wrData[0];
        REG_ON:   onWord     <= satWord(wrData);
        REG_HYST: hystWord   <= satWord(wrData);
        REG_DBNC: dbField    <= wrData[DB_W-1:0];
        REG_MASK: maskOn     <= wrData[0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    onEff   = useDefault ? CUR_W'(DEF_ON) : onWord;
    hystEff = useDefault ? CUR_W'(DEF_HYST) : hystWord;
    strb.tick     = frameTick;
    strb.clrStb   = wrEn && (regAddr_t'(wrAddr) == REG_CLR);
    strb.onLevel  = onEff;
    strb.offLevel = (onEff > hystEff) ? (onEff - hystEff) : '0;
    strb.dbLimit  = dbField;
  end
endmodule

// File: rtl/hook_watch_chan.sv
module hook_watch_chan #(
  parameter int CUR_W = 8,
  parameter int DB_W  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic [CUR_W-1:0] sample,
  input  logic [CUR_W-1:0] onLevel,
  input  logic [CUR_W-1:0] offLevel,
  input  logic [DB_W-1:0]  dbLimit,
  output logic             hookState,
  output logic             changed
);
  logic            rawHk;
  logic            rawNow;
  logic            disagree;
  logic            hit;
  logic [DB_W-1:0] cnt;

  always_comb begin
    rawNow   = rawHk ? (sample >= offLevel) : (sample >= onLevel);
    disagree = rawNow != hookState;
    hit      = disagree && (cnt >= dbLimit);
    changed  = tick && hit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rawHk     <= 1'b0;
      hookState <= 1'b0;
      cnt       <= '0;
    end else if (tick) begin
      rawHk <= rawNow;
      if (hit) begin
        hookState <= rawNow;
        cnt       <= '0;
      end else if (disagree) begin
        cnt <= cnt + 1'b1;
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/hook_watch_dp.sv
module hook_watch_dp
  import hook_watch_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strb,
  input  logic                 maskOn,
  input  logic [NCH*CUR_W-1:0] loopCur,
  input  logic [NCH-1:0]       clrBits,
  output logic [NCH-1:0]       hookStatus,
  output logic [NCH-1:0]       irqFlags,
  output logic                 irq
);
  logic [NCH-1:0] changedVec;
  logic [NCH-1:0] clrVec;

  for (genvar n = 0; n < NCH; n++) begin : gChan
    hook_watch_chan #(.CUR_W(CUR_W), .DB_W(DB_W)) uChan (
      .clk      (clk),
      .rstN     (rstN),
      .tick     (strb.tick),
      .sample   (loopCur[n*CUR_W +: CUR_W]),
      .onLevel  (strb.onLevel),
      .offLevel (strb.offLevel),
      .dbLimit  (strb.dbLimit),
      .hookState(hookStatus[n]),
      .changed  (changedVec[n])
    );
  end

  assign clrVec = strb.clrStb ? clrBits : '0;

  always_ff @(posedge clk) begin
    if (!rstN) irqFlags <= '0;
    else       irqFlags <= (irqFlags & ~clrVec) | changedVec;
  end

  assign irq = (|irqFlags) && !maskOn;
endmodule

// File: rtl/hook_watch.sv
module hook_watch
  import hook_watch_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 frameTick,
  input  logic [NCH*CUR_W-1:0] loopCur,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [DATA_W-1:0]    wrData,
  output logic [NCH-1:0]       hookStatus,
  output logic [NCH-1:0]       irqFlags,
  output logic                 irq
);
  ctrlStrobe_t strb;
  logic        maskOn;

  hook_watch_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .frameTick(frameTick),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .strb     (strb),
    .maskOn   (maskOn)
  );

  hook_watch_dp #(.NCH(NCH)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .maskOn    (maskOn),
    .loopCur   (loopCur),
    .clrBits   (wrData[NCH-1:0]),
    .hookStatus(hookStatus),
    .irqFlags  (irqFlags),
    .irq       (irq)
  );
endmodule

// File: rtl/hook_watch_chk.sv
module hook_watch_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rstN,
  input logic           frameTick,
  input logic           maskOn,
  input logic [NCH-1:0] hookStatus,
  input logic [NCH-1:0] irqFlags,
  input logic           irq
);
  AST_STATUS_TICK_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    !frameTick |=> $stable(hookStatus)); // R6

  AST_FLAG_ON_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    frameTick |=> (((hookStatus ^ $past(hookStatus)) & ~irqFlags) == '0)); // R7

  AST_FLAG_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    ((irqFlags & ~$past(irqFlags)) != '0) |-> ((hookStatus ^ $past(hookStatus)) != '0)); // R7

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    maskOn |-> !irq); // R8

  AST_IRQ_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    (!maskOn && (irqFlags != '0)) |-> irq); // R7
endmodule

bind hook_watch hook_watch_chk #(.NCH(NCH)) uChk (.*);

// File: tb/hook_watch_test.sv
module hook_watch_test;
  localparam int NCH = 4;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            frameTick = 1'b0;
  logic [NCH*8-1:0] loopCur = '0;
  logic            wrEn = 1'b0;
  logic [2:0]      wrAddr = '0;
  logic [7:0]      wrData = '0;
  logic [NCH-1:0]  hookStatus;
  logic [NCH-1:0]  irqFlags;
  logic            irq;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  hook_watch #(.NCH(NCH)) uut (.*);

  always #5 clk = ~clk;

  // behavioural reference
  int mSel = 1, mOn = 0, mHyst = 0, mDb = 0, mMask = 0;
  int mRaw[NCH], mCnt[NCH], mDeb[NCH], mFlag[NCH], setv[NCH];
  int onE, hyE, lowE, cur, r;

  always @(posedge clk) begin
    if (!rstN) begin
      mSel = 1; mOn = 0; mHyst = 0; mDb = 0; mMask = 0;
      for (int n = 0; n < NCH; n++) begin
        mRaw[n] = 0; mCnt[n] = 0; mDeb[n] = 0; mFlag[n] = 0;
      end
    end else begin
      for (int n = 0; n < NCH; n++) setv[n] = 0;
      if (frameTick) begin
        onE = mSel ? 70 : mOn;
        hyE = mSel ? 20 : mHyst;
        lowE = onE - hyE;
        if (lowE < 0) lowE = 0;
        for (int n = 0; n < NCH; n++) begin
          cur = int'(loopCur[n*8 +: 8]);
          r = mRaw[n] ? int'(cur >= lowE) : int'(cur >= onE);
          mRaw[n] = r;
          if (r != mDeb[n]) begin
            if (mCnt[n] >= mDb) begin
              mDeb[n] = r; mCnt[n] = 0; setv[n] = 1;
            end else mCnt[n]++;
          end else if (mCnt[n] > 0) mCnt[n]--;
        end
      end
      if (wrEn) begin
        case (wrAddr)
          3'd0: mSel = int'(wrData[0]);
          3'd1: mOn = (wrData > 200) ? 200 : int'(wrData);
          3'd2: mHyst = (wrData > 200) ? 200 : int'(wrData);
          3'd3: mDb = int'(wrData[3:0]);
          3'd4: mMask = int'(wrData[0]);
          3'd5: for (int n = 0; n < NCH; n++) if (wrData[n]) mFlag[n] = 0;
          default: ;
        endcase
      end
      for (int n = 0; n < NCH; n++) if (setv[n] != 0) mFlag[n] = 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      logic [NCH-1:0] eS, eF;
      logic eI;
      for (int n = 0; n < NCH; n++) begin
        eS[n] = (mDeb[n] != 0);
        eF[n] = (mFlag[n] != 0);
      end
      eI = (eF != '0) && (mMask == 0);
      check(hookStatus == eS, "R5 status vs model", int'(hookStatus), int'(eS));
      check(irqFlags == eF, "R7 flags vs model", int'(irqFlags), int'(eF));
      check(irq == eI, "R7 irq vs model", int'(irq), int'(eI));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic frame(input int a, input int b, input int c, input int d);
    @(negedge clk);
    loopCur = {d[7:0], c[7:0], b[7:0], a[7:0]};
    frameTick = 1'b1;
    @(negedge clk);
    frameTick = 1'b0;
    loopCur = '1;
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = addr[2:0]; wrData = data[7:0];
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(hookStatus == 4'b0000, "R1 status", int'(hookStatus), 0);
    check(irqFlags == 4'b0000, "R1 flags", int'(irqFlags), 0);
    check(irq == 1'b0, "R1 irq", int'(irq), 0);

    frame(70, 69, 0, 0);
    check(hookStatus == 4'b0001, "R2 on-level 70", int'(hookStatus), 1);
    check(irqFlags == 4'b0001 && irq, "R7 flag and irq", int'(irqFlags), 1);

    frame(55, 0, 0, 0);
    check(hookStatus == 4'b0001, "R3 inside band", int'(hookStatus), 1);
    frame(50, 0, 0, 0);
    check(hookStatus == 4'b0001, "R3 off-level 50 holds", int'(hookStatus), 1);
    frame(49, 0, 0, 0);
    check(hookStatus == 4'b0000, "R3 release at 49", int'(hookStatus), 0);

    wr(5, 1);
    check(irqFlags == 4'b0000 && !irq, "R9 clear", int'(irqFlags), 0);

    wr(4, 1);
    frame(90, 0, 0, 0);
    check(irqFlags == 4'b0001, "R8 flag collects", int'(irqFlags), 1);
    check(irq == 1'b0, "R8 masked irq", int'(irq), 0);
    wr(4, 0);
    check(irq == 1'b1, "R8 unmask exposes", int'(irq), 1);
    wr(5, 15);

    @(negedge clk);
    loopCur = '1;
    repeat (5) @(negedge clk);
    check(hookStatus == 4'b0001, "R6 no tick ignored", int'(hookStatus), 1);

    wr(3, 3);
    frame(90, 0, 100, 0);
    frame(90, 0, 100, 0);
    frame(90, 0, 100, 0);
    check(hookStatus == 4'b0001, "R5 three ticks hold", int'(hookStatus), 1);
    frame(90, 0, 0, 0);
    frame(90, 0, 100, 0);
    check(hookStatus == 4'b0001, "R5 count stepped down", int'(hookStatus), 1);
    frame(90, 0, 100, 0);
    check(hookStatus == 4'b0101, "R5 flip", int'(hookStatus), 5);

    wr(3, 0);
    wr(0, 0);
    wr(1, 250);
    wr(2, 230);
    frame(90, 199, 0, 0);
    check(hookStatus == 4'b0101, "R4 saturated 200 and floor 0", int'(hookStatus), 5);
    frame(90, 200, 0, 0);
    check(hookStatus == 4'b0111, "R4 on at 200", int'(hookStatus), 7);
    wr(1, 30);
    wr(2, 10);
    frame(19, 200, 25, 29);
    check(hookStatus == 4'b0110, "R4 programmed words", int'(hookStatus), 6);

    wr(0, 1);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      frameTick = ($urandom_range(0, 2) == 0);
      for (int n = 0; n < NCH; n++) loopCur[n*8 +: 8] = 8'($urandom_range(0, 120));
      wrEn = ($urandom_range(0, 7) == 0);
      wrAddr = 3'($urandom_range(0, 5));
      wrData = 8'($urandom_range(0, 255));
      if (wrAddr == 3'd4 && $urandom_range(0, 3) != 0) wrData[0] = 1'b0;
      if (wrAddr == 3'd3) wrData[3:2] = 2'b00;
    end
    @(negedge clk);
    frameTick = 1'b0; wrEn = 1'b0;
    repeat (3) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule